// File: doc/BRIEF.md
# Pipelined Transmit Read Request Issuer

This block turns transmit packet fetch jobs into a stream of memory read requests. A job gives a start address, a byte length and a context identifier. The block cuts the job into requests no larger than a size cap, gives each one a tag from a small pool, and presents tag, address and byte count on a valid/ready request port. A tag stays in use until a completion-done pulse carrying that tag comes back. Only then can the tag be handed out again.

The size cap and the number of requests that may be outstanding both follow a pipelining enable bit. When the bit is set, up to four requests can be in flight. They may come from one job or from consecutive jobs, and each one is capped at 512 bytes. When the bit is clear, requests go out one at a time and each one is capped at 2048 bytes. In both modes the cap is also limited by the configured maximum read request size. Jobs are handled strictly in order. When a job's context differs from the previous job's context, its first request waits until every earlier request has completed.

Top module: `tx_rdreq_issuer`

## Requirements
- R1: After reset, `req_valid` is 0, `job_ready` is 1 and all four tags are free.
- R2: With pipelining on, each request carries min(512, size-code bytes, remaining length) bytes. The first request uses the job start address, each later request's address is the previous address plus the previous byte count, and the last request carries the remainder.
- R3: With pipelining off, each request carries min(2048, size-code bytes, remaining length) bytes, with the same address stepping as R2.
- R4: With pipelining on, at most four requests are outstanding. While four are outstanding, `req_valid` stays 0 until a completion arrives.
- R5: With pipelining off, at most one request is outstanding. While one is outstanding, `req_valid` stays 0.
- R6: A job is accepted only when `job_ready` is 1. `job_ready` stays 0 from acceptance until the job's last request is taken, so every request of a job is issued before any request of the next job.
- R7: The first request of a job whose context differs from the context of the previously issued job is held back until nothing is outstanding. A job with the same context issues while earlier requests are still outstanding.
- R8: A request carries the lowest-numbered free tag. A `cpl_done` pulse frees the tag on `cpl_tag`. A pulse naming a tag that is already free has no effect.
- R9: The pipelining bit resets to the parameter `PIPE_EN_INIT` (default 1). It loads `cfg_pipe_en` on a clock edge where `cfg_we` is 1.
- R10: `rd_size_code` values 0 to 5 select 128 << code bytes (128, 256, 512, 1024, 2048, 4096). Codes 6 and 7 select 4096.
- R11: A job of length 0 is accepted and completes without issuing any request. `job_ready` returns to 1 on the next cycle.
- R12: While `req_valid` is 1 and `req_ready` is 0, `req_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the pipelining bit |
| cfg_pipe_en | input | 1 | Value loaded into the pipelining bit |
| rd_size_code | input | 3 | Maximum read request size code |
| job_valid | input | 1 | Fetch job offered |
| job_ready | output | 1 | Block can take a job |
| job_addr | input | AW (32) | Job start address |
| job_len | input | LW (16) | Job length in bytes |
| job_ctx | input | CW (4) | Job context identifier |
| req_valid | output | 1 | Read request presented |
| req_ready | input | 1 | Request taken on this edge |
| req_tag | output | 2 | Request tag |
| req_addr | output | AW (32) | Request address |
| req_len | output | 13 | Request byte count |
| cpl_done | input | 1 | Completion of a tag fully delivered |
| cpl_tag | input | 2 | Tag of the delivered completion |

## Verification
The hardest situation to reach is a context-change stall that overlaps outstanding requests from two earlier jobs with the same context. Setting it up takes a full pool, a same-context job that pipelines behind it, and then a different-context job. The bench withholds completions while it builds this case. It then releases the completions one at a time and checks at each step that the held job stays blocked until the last tag returns. The other hard case is a tag freed out of order while the pool is full. The bench completes a middle tag first and checks that this tag is the next one reused.

// File: rtl/txrd_pkg.sv
// Package: shared widths and the read-size decode for the transmit read
// request issuer. Assumes request byte counts never exceed 4096.
package txrd_pkg;

    localparam int RD_SZ_W = 13;

    // Decode the 3-bit maximum read size code into bytes; codes 6 and 7 saturate.
    function automatic logic [RD_SZ_W-1:0] size_code_bytes(input logic [2:0] code);
        logic [RD_SZ_W-1:0] b;
        case (code)
            3'd0: b = 13'd128;
            3'd1: b = 13'd256;
            3'd2: b = 13'd512;
            3'd3: b = 13'd1024;
            3'd4: b = 13'd2048;
            default: b = 13'd4096;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/txrd_cfg_bit.sv
// Module: holds the pipelining enable bit. It resets to a parameter value and
// loads a new value on a write strobe. Assumes the write strobe is synchronous.
module txrd_cfg_bit #(
    parameter logic INIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wdata,
    output logic q
);

    // Register the enable bit, loading on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/txrd_size_limit.sv
// Module: computes the per-request byte cap from the pipelining bit and the
// size code. Assumes PIPE_MAX and SERIAL_MAX fit in RD_SZ_W bits.
module txrd_size_limit
    import txrd_pkg::*;
#(
    parameter int PIPE_MAX   = 512,
    parameter int SERIAL_MAX = 2048
) (
    input  logic               pipe_en,
    input  logic [2:0]         size_code,
    output logic [RD_SZ_W-1:0] max_bytes
);

    localparam logic [RD_SZ_W-1:0] PIPE_CAP   = RD_SZ_W'(PIPE_MAX);
    localparam logic [RD_SZ_W-1:0] SERIAL_CAP = RD_SZ_W'(SERIAL_MAX);

    logic [RD_SZ_W-1:0] code_bytes;
    logic [RD_SZ_W-1:0] mode_cap;

    // Take the smaller of the mode cap and the decoded size code.
    always_comb begin
        code_bytes = size_code_bytes(size_code);
        mode_cap   = pipe_en ? PIPE_CAP : SERIAL_CAP;
        max_bytes  = (code_bytes < mode_cap) ? code_bytes : mode_cap;
    end

endmodule

// File: rtl/txrd_tag_pool.sv
// Module: tracks which request tags are in flight. It offers the lowest free
// tag and counts busy tags. A take and a give may happen on the same edge.
// Assumes a give for a tag that is not busy should be ignored.
module txrd_tag_pool #(
    parameter int NUM_TAGS = 4,
    localparam int TAG_W = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1,
    localparam int CNT_W = $clog2(NUM_TAGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [TAG_W-1:0] take_tag,
    input  logic             give,
    input  logic [TAG_W-1:0] give_tag,
    output logic [TAG_W-1:0] free_tag,
    output logic             any_free,
    output logic [CNT_W-1:0] busy_cnt
);

    logic [NUM_TAGS-1:0] busy;
    logic [NUM_TAGS-1:0] take_mask;
    logic [NUM_TAGS-1:0] give_mask;

    // Decode the take and give strobes into one-hot masks.
    always_comb begin
        take_mask = '0;
        give_mask = '0;
        if (take) take_mask[take_tag] = 1'b1;
        if (give) give_mask[give_tag] = 1'b1;
    end

    // Update the busy set: release first, then mark the newly issued tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
        end else begin
            busy <= (busy & ~give_mask) | take_mask;
        end
    end

    // Priority-pick the lowest-numbered free tag.
    always_comb begin
        free_tag = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (!busy[i]) free_tag = TAG_W'(i);
        end
    end

    // Report whether any tag is free and how many are busy.
    always_comb begin
        any_free = |(~busy);
        busy_cnt = CNT_W'($countones(busy));
    end

endmodule

// File: rtl/txrd_job_splitter.sv
// Module: holds the current fetch job and cuts it into requests of at most
// max_bytes. It steps the address and remaining length on each taken request,
// remembers the context of the last issued job, and flags a first request
// whose context changed. Assumes LW >= RD_SZ_W.
module txrd_job_splitter
    import txrd_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int CW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               job_valid,
    output logic               job_ready,
    input  logic [AW-1:0]      job_addr,
    input  logic [LW-1:0]      job_len,
    input  logic [CW-1:0]      job_ctx,
    input  logic [RD_SZ_W-1:0] max_bytes,
    input  logic               take,
    output logic               active,
    output logic               need_drain,
    output logic [AW-1:0]      cur_addr,
    output logic [RD_SZ_W-1:0] cur_len
);

    logic [LW-1:0] rem;
    logic [CW-1:0] ctx;
    logic [CW-1:0] last_ctx;
    logic          first;
    logic          ctx_seen;
    logic          job_take;
    logic          last_piece;

    assign job_ready = !active;
    assign job_take  = job_valid && job_ready;

    // Size the next piece: the full cap, or what is left of the job.
    always_comb begin
        if (rem < LW'(max_bytes)) begin
            cur_len = RD_SZ_W'(rem);
        end else begin
            cur_len = max_bytes;
        end
        last_piece = (rem == LW'(cur_len));
    end

    // Flag a first request whose context differs from the last issued one.
    always_comb begin
        need_drain = first && (!ctx_seen || (ctx != last_ctx));
    end

    // Load a job, then step address and remaining length per taken request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cur_addr <= '0;
            rem      <= '0;
            ctx      <= '0;
            first    <= 1'b0;
        end else if (job_take) begin
            active   <= (job_len != '0);
            cur_addr <= job_addr;
            rem      <= job_len;
            ctx      <= job_ctx;
            first    <= 1'b1;
        end else if (take) begin
            cur_addr <= cur_addr + AW'(cur_len);
            rem      <= rem - LW'(cur_len);
            first    <= 1'b0;
            if (last_piece) active <= 1'b0;
        end
    end

    // Record the context of a job once its first request is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ctx <= '0;
            ctx_seen <= 1'b0;
        end else if (take && first) begin
            last_ctx <= ctx;
            ctx_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/tx_rdreq_issuer.sv
// Module: top of the pipelined transmit read request issuer. It combines the
// job splitter, the tag pool, the size cap and the pipelining bit, and gates
// request issue by the outstanding limit and the context-change drain.
// Assumes req_ready may be held high and that a completion is only reported
// for a tag that was issued.
module tx_rdreq_issuer
    import txrd_pkg::*;
#(
    parameter int   AW           = 32,
    parameter int   LW           = 16,
    parameter int   CW           = 4,
    parameter int   NUM_TAGS     = 4,
    parameter int   PIPE_MAX     = 512,
    parameter int   SERIAL_MAX   = 2048,
    parameter logic PIPE_EN_INIT = 1'b1,
    localparam int  TAG_W        = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1,
    localparam int  CNT_W        = $clog2(NUM_TAGS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_pipe_en,
    input  logic [2:0]         rd_size_code,
    input  logic               job_valid,
    output logic               job_ready,
    input  logic [AW-1:0]      job_addr,
    input  logic [LW-1:0]      job_len,
    input  logic [CW-1:0]      job_ctx,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [TAG_W-1:0]   req_tag,
    output logic [AW-1:0]      req_addr,
    output logic [RD_SZ_W-1:0] req_len,
    input  logic               cpl_done,
    input  logic [TAG_W-1:0]   cpl_tag
);

    localparam logic [CNT_W-1:0] PIPE_LIMIT   = CNT_W'(NUM_TAGS);
    localparam logic [CNT_W-1:0] SERIAL_LIMIT = CNT_W'(1);

    logic               pipe_en_q;
    logic [RD_SZ_W-1:0] max_bytes;
    logic               active;
    logic               need_drain;
    logic [TAG_W-1:0]   free_tag;
    logic               any_free;
    logic [CNT_W-1:0]   busy_cnt;
    logic [CNT_W-1:0]   out_limit;
    logic               fire;

    txrd_cfg_bit #(
        .INIT (PIPE_EN_INIT)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_pipe_en),
        .q     (pipe_en_q)
    );

    txrd_size_limit #(
        .PIPE_MAX   (PIPE_MAX),
        .SERIAL_MAX (SERIAL_MAX)
    ) u_size (
        .pipe_en   (pipe_en_q),
        .size_code (rd_size_code),
        .max_bytes (max_bytes)
    );

    txrd_job_splitter #(
        .AW (AW),
        .LW (LW),
        .CW (CW)
    ) u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .job_valid  (job_valid),
        .job_ready  (job_ready),
        .job_addr   (job_addr),
        .job_len    (job_len),
        .job_ctx    (job_ctx),
        .max_bytes  (max_bytes),
        .take       (fire),
        .active     (active),
        .need_drain (need_drain),
        .cur_addr   (req_addr),
        .cur_len    (req_len)
    );

    txrd_tag_pool #(
        .NUM_TAGS (NUM_TAGS)
    ) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (fire),
        .take_tag (free_tag),
        .give     (cpl_done),
        .give_tag (cpl_tag),
        .free_tag (free_tag),
        .any_free (any_free),
        .busy_cnt (busy_cnt)
    );

    // Gate issue on a job, a free tag, the mode limit and the context drain.
    always_comb begin
        out_limit = pipe_en_q ? PIPE_LIMIT : SERIAL_LIMIT;
        req_valid = active && any_free && (busy_cnt < out_limit)
                    && !(need_drain && (busy_cnt != '0));
        req_tag   = free_tag;
        fire      = req_valid && req_ready;
    end

endmodule

// File: rtl/tx_rdreq_issuer_chk.sv
// Module: assertion checker for the issuer. It rebuilds the in-flight tag set
// from the request and completion ports and checks the issue rules against it.
module tx_rdreq_issuer_chk #(
    parameter int  AW         = 32,
    parameter int  NUM_TAGS   = 4,
    parameter int  PIPE_MAX   = 512,
    parameter int  SERIAL_MAX = 2048,
    localparam int TAG_W      = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [TAG_W-1:0] req_tag,
    input logic [AW-1:0]    req_addr,
    input logic [12:0]      req_len,
    input logic             cpl_done,
    input logic [TAG_W-1:0] cpl_tag,
    input logic             job_ready,
    input logic             pipe_en_q
);

    logic [NUM_TAGS-1:0] inflight;

    // Track tags seen on the request port until their completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= '0;
        end else begin
            for (int i = 0; i < NUM_TAGS; i++) begin
                if (req_valid && req_ready && (TAG_W'(i) == req_tag)) begin
                    inflight[i] <= 1'b1;
                end else if (cpl_done && (TAG_W'(i) == cpl_tag)) begin
                    inflight[i] <= 1'b0;
                end
            end
        end
    end

    assert_tag_unused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !inflight[req_tag]);

    assert_full_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (&inflight) |-> !req_valid);

    assert_serial_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_en_q && (inflight != '0)) |-> !req_valid);

    assert_pipe_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pipe_en_q) |-> ((req_len != 13'd0) && (int'(req_len) <= PIPE_MAX)));

    assert_serial_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pipe_en_q) |-> ((req_len != 13'd0) && (int'(req_len) <= SERIAL_MAX)));

    assert_job_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !job_ready);

    assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> $stable(req_addr));

endmodule

bind tx_rdreq_issuer tx_rdreq_issuer_chk #(
    .AW         (AW),
    .NUM_TAGS   (NUM_TAGS),
    .PIPE_MAX   (PIPE_MAX),
    .SERIAL_MAX (SERIAL_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_tag   (req_tag),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .cpl_done  (cpl_done),
    .cpl_tag   (cpl_tag),
    .job_ready (job_ready),
    .pipe_en_q (pipe_en_q)
);

// File: tb/tx_rdreq_issuer_tb.sv
// Bench: walks a table of size-cap vectors, then runs directed tests for
// reset, pipelining depth, tag reuse, context drain and zero-length jobs.
module tx_rdreq_issuer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_pipe_en = 1'b0;
    logic [2:0]  rd_size_code = 3'd2;
    logic        job_valid = 1'b0;
    logic        job_ready;
    logic [31:0] job_addr = '0;
    logic [15:0] job_len = '0;
    logic [3:0]  job_ctx = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [1:0]  req_tag;
    logic [31:0] req_addr;
    logic [12:0] req_len;
    logic        cpl_done = 1'b0;
    logic [1:0]  cpl_tag = '0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tx_rdreq_issuer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_pipe_en  (cfg_pipe_en),
        .rd_size_code (rd_size_code),
        .job_valid    (job_valid),
        .job_ready    (job_ready),
        .job_addr     (job_addr),
        .job_len      (job_len),
        .job_ctx      (job_ctx),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_tag      (req_tag),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .cpl_done     (cpl_done),
        .cpl_tag      (cpl_tag)
    );

    typedef struct packed {
        logic        pipe;
        logic [2:0]  code;
        logic [15:0] len;
        logic [12:0] cap;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 3'd0, 16'd300,  13'd128},
        '{1'b1, 3'd2, 16'd1000, 13'd512},
        '{1'b1, 3'd5, 16'd1300, 13'd512},
        '{1'b0, 3'd3, 16'd2500, 13'd1024},
        '{1'b0, 3'd5, 16'd4100, 13'd2048},
        '{1'b0, 3'd6, 16'd3000, 13'd2048},
        '{1'b0, 3'd1, 16'd256,  13'd256},
        '{1'b1, 3'd7, 16'd512,  13'd512}
    };

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic set_mode(input logic p);
        cfg_pipe_en = p;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic submit(input logic [31:0] a, input logic [15:0] l, input logic [3:0] c);
        job_addr  = a;
        job_len   = l;
        job_ctx   = c;
        job_valid = 1'b1;
        @(negedge clk);
        job_valid = 1'b0;
    endtask

    task automatic fire_one();
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic complete(input logic [1:0] t);
        cpl_tag  = t;
        cpl_done = 1'b1;
        @(negedge clk);
        cpl_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        int rem;
        logic [31:0] a;
        int exp_len;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_valid == 1'b0, "R1 req_valid in reset", int'(req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(job_ready == 1'b1, "R1 job_ready after reset", int'(job_ready), 1);
        chk(req_valid == 1'b0, "R1 req_valid after reset", int'(req_valid), 0);

        // R9: reset value of the pipelining bit shows up as the 512-byte cap
        rd_size_code = 3'd5;
        submit(32'h100, 16'd1024, 4'd0);
        chk(req_len == 13'd512, "R9 cap after reset", int'(req_len), 512);
        chk(req_tag == 2'd0, "R1 first tag free", int'(req_tag), 0);
        fire_one();
        chk(req_addr == 32'h300, "R2 address step", int'(req_addr), 'h300);
        fire_one();
        complete(2'd0);
        complete(2'd1);

        // R2 R3 R10: table of size caps walked one request at a time
        for (int i = 0; i < NVEC; i++) begin
            set_mode(VECS[i].pipe);
            rd_size_code = VECS[i].code;
            a = 32'h1000 * (i + 1) + 32'h40;
            submit(a, VECS[i].len, 4'd0);
            rem = int'(VECS[i].len);
            n = 0;
            while (rem > 0 && n < 64) begin
                exp_len = (rem < int'(VECS[i].cap)) ? rem : int'(VECS[i].cap);
                chk(req_valid == 1'b1, "R2/R3 request valid", int'(req_valid), 1);
                chk(int'(req_len) == exp_len, "R10 request length (R2/R3)", int'(req_len), exp_len);
                chk(req_addr == a, "R2/R3 request address", int'(req_addr), int'(a));
                fire_one();
                complete(2'd0);
                rem -= exp_len;
                a += 32'(exp_len);
                n++;
            end
            chk(job_ready == 1'b1, "R6 job done after last piece", int'(job_ready), 1);
        end

        // R4 R8 R12: full pipeline, out-of-order tag return
        set_mode(1'b1);
        rd_size_code = 3'd2;
        submit(32'h2_0000, 16'd3000, 4'd0);
        req_ready = 1'b1;
        n = 0;
        for (int k = 0; k < 6; k++) begin
            if (req_valid) begin
                chk(int'(req_tag) == n, "R8 lowest free tag", int'(req_tag), n);
                chk(req_addr == 32'h2_0000 + 32'(512 * n), "R2 pipelined address",
                    int'(req_addr), 'h2_0000 + 512 * n);
                n++;
            end
            @(negedge clk);
        end
        req_ready = 1'b0;
        chk(n == 4, "R4 four outstanding", n, 4);
        chk(req_valid == 1'b0, "R4 stall when full", int'(req_valid), 0);
        chk(job_ready == 1'b0, "R6 job still open", int'(job_ready), 0);
        complete(2'd2);
        chk(req_valid == 1'b1 && req_tag == 2'd2, "R8 freed tag reused", int'(req_tag), 2);
        a = req_addr;
        @(negedge clk);
        chk(req_addr == a, "R12 address held while stalled", int'(req_addr), int'(a));
        fire_one();
        chk(req_valid == 1'b0, "R4 full again", int'(req_valid), 0);
        complete(2'd0);
        chk(req_len == 13'd440, "R2 last piece remainder", int'(req_len), 440);
        chk(req_addr == 32'h2_0A00, "R2 last piece address", int'(req_addr), 'h2_0A00);
        fire_one();
        chk(job_ready == 1'b1, "R6 ready after last request", int'(job_ready), 1);
        for (int t = 0; t < 4; t++) complete(2'(t));

        // R7: same context pipelines, a new context drains first
        submit(32'h3_0000, 16'd1024, 4'd5);
        fire_one();
        fire_one();
        submit(32'h3_1000, 16'd100, 4'd5);
        chk(req_valid == 1'b1 && req_tag == 2'd2, "R7 same context issues", int'(req_valid), 1);
        fire_one();
        submit(32'h3_2000, 16'd100, 4'd6);
        chk(req_valid == 1'b0, "R7 new context held", int'(req_valid), 0);
        complete(2'd0);
        complete(2'd1);
        chk(req_valid == 1'b0, "R7 held while one outstanding", int'(req_valid), 0);
        complete(2'd2);
        chk(req_valid == 1'b1 && req_tag == 2'd0, "R7 issues after drain", int'(req_valid), 1);
        chk(req_addr == 32'h3_2000, "R7 drained job address", int'(req_addr), 'h3_2000);
        fire_one();
        complete(2'd0);

        // R8: a completion for a free tag has no effect
        complete(2'd3);
        submit(32'h4_0000, 16'd2048, 4'd6);
        req_ready = 1'b1;
        n = 0;
        for (int k = 0; k < 6; k++) begin
            if (req_valid) n++;
            @(negedge clk);
        end
        req_ready = 1'b0;
        chk(n == 4, "R8 stray completion ignored", n, 4);
        for (int t = 0; t < 4; t++) complete(2'(t));

        // R5 R9: serial mode after a register write
        set_mode(1'b0);
        rd_size_code = 3'd5;
        submit(32'h5_0000, 16'd5000, 4'd6);
        chk(req_len == 13'd2048, "R9 serial cap after write", int'(req_len), 2048);
        fire_one();
        chk(req_valid == 1'b0, "R5 one outstanding", int'(req_valid), 0);
        complete(2'd0);
        chk(req_valid == 1'b1 && req_addr == 32'h5_0800, "R5 next after completion",
            int'(req_addr), 'h5_0800);
        fire_one();
        complete(2'd0);
        chk(req_len == 13'd904, "R3 serial remainder", int'(req_len), 904);
        fire_one();
        complete(2'd0);

        // R11: zero-length job
        submit(32'h6_0000, 16'd0, 4'd6);
        chk(job_ready == 1'b1, "R11 zero-length job ready", int'(job_ready), 1);
        chk(req_valid == 1'b0, "R11 zero-length no request", int'(req_valid), 0);

        finish_run();
    end

endmodule